// File: doc/BRIEF.md
# Instruction-Driven Waveform Pattern Sequencer

This block produces a single-bit waveform by running a short program stored in a local instruction memory. Each 16-bit word either drives the line to a level for a counted number of clock cycles or controls a counted loop. Loops may be nested. Software, or a loader upstream, writes the words through a plain write port. It then gives the program length and pulses `start`. The sequencer runs the program and raises `done` when the last segment has been played.

Internally the design has two halves. An instruction engine walks the program one word per cycle. It resolves loop control and pushes resolved level segments into a small queue. A player drains the queue and produces the waveform. Fetch and loop overhead are therefore hidden behind the time a segment takes to play. `active` marks every cycle in which a segment is being emitted, so that a low segment can be told apart from an idle line.

Counts are plain binary values. Any textual number format is converted before loading.

Top module: `wg_pattern_seq`

## Requirements
- R1: An instruction word carries its opcode in bits 15:14 and an unsigned count N in bits 13:0. Opcode 00 drives `wave_out` to 1 for exactly N consecutive cycles, with `active` high in each of those cycles.
- R2: Opcode 01 drives `wave_out` to 0 for exactly N consecutive cycles, with `active` high in each of those cycles.
- R3: Opcode 10 opens a loop whose body (the words up to the matching opcode-11 word) runs N times in total.
- R4: Opcode 11 closes the innermost open loop. It sends execution back to the first body word until the loop's count is used up, then continues after itself. An opcode-11 word with no open loop has no effect.
- R5: Loops nest up to STACK_DEPTH levels (default 4), and each level keeps its own count.
- R6: A count of zero on opcode 00 or 01 emits nothing. Opcode 10 with count zero skips its whole body, including any loops nested inside it.
- R7: Successive segments are emitted back to back with no inactive cycle, provided the engine keeps ahead of the player. The engine keeps ahead when each segment lasts longer than the control words resolved before it.
- R8: After the last segment, `done` is high and `wave_out` and `active` are low. `done` stays high until the next `start`, and is low in the cycle after `start`. A program length of zero completes with no output.
- R9: Writes with `prog_we` store `prog_data` at `prog_addr`. The program is the words at addresses 0 to `prog_len`-1, with `prog_len` sampled at `start`. A new `start` replays the stored program unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_we | input | 1 | Instruction write strobe |
| prog_addr | input | ADDR_W | Instruction write address |
| prog_data | input | 16 | Instruction word: opcode in bits 15:14, count in bits 13:0 |
| prog_len | input | ADDR_W+1 | Number of program words, sampled at start |
| start | input | 1 | One-cycle pulse that (re)starts execution at address 0 |
| wave_out | output | 1 | Generated waveform |
| active | output | 1 | High in every cycle a segment is being emitted |
| done | output | 1 | Program finished; held until the next start |

## Verification
On every cycle, the checker confirms four things. A segment longer than one cycle holds its level and stays active into the next cycle. The player never idles while it finishes a segment with another segment already queued. Loop nesting never exceeds the stack depth. `done` is quiet, sticky and cleared by `start`.

Only the bench scenarios can show the exact cycle counts and order of the emitted levels. This covers plain segments, single and nested loops, zero-count skipping, stray loop ends, an empty program and a replay. The bench compares the waveform cycle by cycle against streams it expands by hand from the program text.

// File: rtl/wg_pkg.sv
package wg_pkg;
   localparam int INSTR_W = 16;
   localparam int OP_W    = 2;
   localparam int CNT_W   = INSTR_W - OP_W;

   typedef enum logic [OP_W-1:0] {
      OP_HIGH = 2'b00,
      OP_LOW  = 2'b01,
      OP_RPT  = 2'b10,
      OP_END  = 2'b11
   } wg_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_SKIP  = 2'd2,
      ST_DRAIN = 2'd3
   } wg_state_e;

   typedef struct packed {
      logic             level;
      logic [CNT_W-1:0] len;
   } wg_seg_t;
endpackage

// File: rtl/wg_prog_mem.sv
module wg_prog_mem
   import wg_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic               clk,
   input  logic               we,
   input  logic [ADDR_W-1:0]  waddr,
   input  logic [INSTR_W-1:0] wdata,
   input  logic [ADDR_W-1:0]  raddr,
   output logic [INSTR_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [INSTR_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/wg_loop_stack.sv
module wg_loop_stack
   import wg_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int PC_W  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               push,
   input  logic [PC_W-1:0]    push_start,
   input  logic [CNT_W-1:0]   push_cnt,
   input  logic               pop,
   input  logic               dec,
   output logic               empty,
   output logic               full,
   output logic [PC_W-1:0]    top_start,
   output logic [CNT_W-1:0]   top_cnt,
   output logic [$clog2(DEPTH+1)-1:0] level
);
   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [PC_W-1:0]  start_q [DEPTH];
   logic [CNT_W-1:0] cnt_q   [DEPTH];
   logic [LVL_W-1:0] sp_q;
   logic [IDX_W-1:0] top_idx, new_idx;

   assign empty   = (sp_q == '0);
   assign full    = (sp_q == LVL_W'(DEPTH));
   assign top_idx = empty ? '0 : IDX_W'(sp_q - LVL_W'(1));
   assign new_idx = full  ? '0 : IDX_W'(sp_q);
   assign top_start = start_q[top_idx];
   assign top_cnt   = cnt_q[top_idx];
   assign level     = sp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            start_q[i] <= '0;
            cnt_q[i]   <= '0;
         end
      end else if (clear) begin
         sp_q <= '0;
      end else if (push && !full) begin
         start_q[new_idx] <= push_start;
         cnt_q[new_idx]   <= push_cnt;
         sp_q             <= sp_q + LVL_W'(1);
      end else if (pop && !empty) begin
         sp_q <= sp_q - LVL_W'(1);
      end else if (dec && !empty) begin
         cnt_q[top_idx] <= cnt_q[top_idx] - CNT_W'(1);
      end
   end
endmodule

// File: rtl/wg_seg_fifo.sv
module wg_seg_fifo
   import wg_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    clear,
   input  logic    push,
   input  wg_seg_t push_data,
   input  logic    pop,
   output wg_seg_t head,
   output logic    empty,
   output logic    full
);
   if (DEPTH == 1) begin : g_single
      logic    valid_q;
      wg_seg_t data_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
         end else if (clear) begin
            valid_q <= 1'b0;
         end else if (push && (!valid_q || pop)) begin
            valid_q <= 1'b1;
            data_q  <= push_data;
         end else if (pop) begin
            valid_q <= 1'b0;
         end
      end

      assign head  = data_q;
      assign empty = !valid_q;
      assign full  = valid_q;
   end else begin : g_ring
      localparam int IDX_W = $clog2(DEPTH);
      localparam int OCC_W = $clog2(DEPTH + 1);

      wg_seg_t          slot_q [DEPTH];
      logic [IDX_W-1:0] wr_q, rd_q;
      logic [OCC_W-1:0] occ_q;
      logic             do_push, do_pop;

      function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
         return (p == IDX_W'(DEPTH - 1)) ? '0 : p + IDX_W'(1);
      endfunction

      assign empty   = (occ_q == '0);
      assign full    = (occ_q == OCC_W'(DEPTH));
      assign do_push = push && !full;
      assign do_pop  = pop && !empty;
      assign head    = slot_q[rd_q];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            occ_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
         end else if (clear) begin
            wr_q  <= '0;
            rd_q  <= '0;
            occ_q <= '0;
         end else begin
            if (do_push) begin
               slot_q[wr_q] <= push_data;
               wr_q         <= nxt(wr_q);
            end
            if (do_pop) rd_q <= nxt(rd_q);
            if (do_push && !do_pop)      occ_q <= occ_q + OCC_W'(1);
            else if (do_pop && !do_push) occ_q <= occ_q - OCC_W'(1);
         end
      end
   end
endmodule

// File: rtl/wg_seg_player.sv
module wg_seg_player
   import wg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             avail,
   input  wg_seg_t          head,
   output logic             take,
   output logic             active,
   output logic             wave,
   output logic [CNT_W-1:0] rem
);
   logic [CNT_W-1:0] rem_q;
   logic             level_q;

   assign take   = avail && !clear && (rem_q <= CNT_W'(1));
   assign active = (rem_q != '0);
   assign wave   = active && level_q;
   assign rem    = rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q   <= '0;
         level_q <= 1'b0;
      end else if (clear) begin
         rem_q   <= '0;
         level_q <= 1'b0;
      end else if (take) begin
         rem_q   <= head.len;
         level_q <= head.level;
      end else if (rem_q != '0) begin
         rem_q <= rem_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/wg_pattern_seq.sv
module wg_pattern_seq
   import wg_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int STACK_DEPTH = 4,
   parameter int QDEPTH      = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               prog_we,
   input  logic [ADDR_W-1:0]  prog_addr,
   input  logic [INSTR_W-1:0] prog_data,
   input  logic [ADDR_W:0]    prog_len,
   input  logic               start,
   output logic               wave_out,
   output logic               active,
   output logic               done
);
   localparam int PC_W  = ADDR_W + 1;
   localparam int LVL_W = $clog2(STACK_DEPTH + 1);

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("wg_pattern_seq: ADDR_W must lie in 1..12");
   end
   if (STACK_DEPTH < 1) begin : g_bad_stack
      $error("wg_pattern_seq: STACK_DEPTH must be at least 1");
   end
   if (QDEPTH < 1) begin : g_bad_queue
      $error("wg_pattern_seq: QDEPTH must be at least 1");
   end

   wg_state_e          st_q, st_d;
   logic [PC_W-1:0]    pc_q, pc_d, len_q, skip_q, skip_d;
   logic               done_q, done_d;
   logic [INSTR_W-1:0] instr;
   wg_op_e             op;
   logic [CNT_W-1:0]   cnt;
   logic               at_end;

   logic               fifo_push, fifo_empty, fifo_full, take;
   wg_seg_t            fifo_head, seg_new;
   logic               stk_push, stk_pop, stk_dec, stk_empty, stk_full;
   logic [PC_W-1:0]    stk_start;
   logic [CNT_W-1:0]   stk_cnt;
   logic [LVL_W-1:0]   stk_level;
   logic [CNT_W-1:0]   play_rem;

   wg_prog_mem #(.ADDR_W(ADDR_W)) u_mem (
      .clk   (clk),
      .we    (prog_we),
      .waddr (prog_addr),
      .wdata (prog_data),
      .raddr (pc_q[ADDR_W-1:0]),
      .rdata (instr)
   );

   assign op      = wg_op_e'(instr[INSTR_W-1 -: OP_W]);
   assign cnt     = instr[CNT_W-1:0];
   assign at_end  = (pc_q >= len_q);
   assign seg_new = '{level: (op == OP_HIGH), len: cnt};

   always_comb begin
      st_d      = st_q;
      pc_d      = pc_q;
      skip_d    = skip_q;
      done_d    = done_q;
      fifo_push = 1'b0;
      stk_push  = 1'b0;
      stk_pop   = 1'b0;
      stk_dec   = 1'b0;
      if (start) begin
         st_d   = ST_RUN;
         pc_d   = '0;
         skip_d = '0;
         done_d = 1'b0;
      end else begin
         unique case (st_q)
            ST_RUN: begin
               if (at_end) begin
                  st_d = ST_DRAIN;
               end else begin
                  unique case (op)
                     OP_HIGH, OP_LOW: begin
                        if (cnt == '0) begin
                           pc_d = pc_q + PC_W'(1);
                        end else if (!fifo_full) begin
                           fifo_push = 1'b1;
                           pc_d      = pc_q + PC_W'(1);
                        end
                     end
                     OP_RPT: begin
                        pc_d = pc_q + PC_W'(1);
                        if (cnt == '0) begin
                           st_d   = ST_SKIP;
                           skip_d = '0;
                        end else begin
                           stk_push = 1'b1;
                        end
                     end
                     OP_END: begin
                        if (stk_empty) begin
                           pc_d = pc_q + PC_W'(1);
                        end else if (stk_cnt == '0) begin
                           stk_pop = 1'b1;
                           pc_d    = pc_q + PC_W'(1);
                        end else begin
                           stk_dec = 1'b1;
                           pc_d    = stk_start;
                        end
                     end
                     default: ;
                  endcase
               end
            end
            ST_SKIP: begin
               if (at_end) begin
                  st_d = ST_DRAIN;
               end else begin
                  pc_d = pc_q + PC_W'(1);
                  if (op == OP_RPT) begin
                     skip_d = skip_q + PC_W'(1);
                  end else if (op == OP_END) begin
                     if (skip_q == '0) st_d = ST_RUN;
                     else              skip_d = skip_q - PC_W'(1);
                  end
               end
            end
            ST_DRAIN: begin
               if (fifo_empty && !active) begin
                  done_d = 1'b1;
                  st_d   = ST_IDLE;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pc_q   <= '0;
         len_q  <= '0;
         skip_q <= '0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         pc_q   <= pc_d;
         skip_q <= skip_d;
         done_q <= done_d;
         if (start) len_q <= prog_len;
      end
   end

   wg_loop_stack #(.DEPTH(STACK_DEPTH), .PC_W(PC_W)) u_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (start),
      .push       (stk_push),
      .push_start (pc_q + PC_W'(1)),
      .push_cnt   (cnt - CNT_W'(1)),
      .pop        (stk_pop),
      .dec        (stk_dec),
      .empty      (stk_empty),
      .full       (stk_full),
      .top_start  (stk_start),
      .top_cnt    (stk_cnt),
      .level      (stk_level)
   );

   wg_seg_fifo #(.DEPTH(QDEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start),
      .push      (fifo_push),
      .push_data (seg_new),
      .pop       (take),
      .head      (fifo_head),
      .empty     (fifo_empty),
      .full      (fifo_full)
   );

   wg_seg_player u_play (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start),
      .avail  (!fifo_empty),
      .head   (fifo_head),
      .take   (take),
      .active (active),
      .wave   (wave_out),
      .rem    (play_rem)
   );

   assign done = done_q;
endmodule

// File: rtl/wg_pattern_seq_chk.sv
module wg_pattern_seq_chk
   import wg_pkg::*;
#(
   parameter int STACK_DEPTH = 4
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           start,
   input logic                           wave_out,
   input logic                           active,
   input logic                           done,
   input logic [$clog2(STACK_DEPTH+1)-1:0] stk_level,
   input logic [CNT_W-1:0]               rem_q,
   input logic                           fifo_empty
);
   // R1
   seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && rem_q > CNT_W'(1) && !start) |=> (active && $stable(wave_out)));

   // R2
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !wave_out);

   // R5
   nest_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stk_level <= ($clog2(STACK_DEPTH+1))'(STACK_DEPTH));

   // R7
   no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && rem_q == CNT_W'(1) && !fifo_empty && !start) |=> active);

   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!active && !wave_out));

   // R8
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   // R8
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done);
endmodule

bind wg_pattern_seq wg_pattern_seq_chk #(.STACK_DEPTH(STACK_DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .wave_out   (wave_out),
   .active     (active),
   .done       (done),
   .stk_level  (stk_level),
   .rem_q      (play_rem),
   .fifo_empty (fifo_empty)
);

// File: tb/tb_wg_pattern_seq.sv
`timescale 1ns/1ps
module tb_wg_pattern_seq;
   localparam int ADDR_W = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              prog_we = 1'b0;
   logic [ADDR_W-1:0] prog_addr = '0;
   logic [15:0]       prog_data = '0;
   logic [ADDR_W:0]   prog_len = '0;
   logic              start = 1'b0;
   logic              wave_out, active, done;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  exp_q[$];
   bit  mon_en = 1'b0;
   bit  seen = 1'b0;
   bit  idle = 1'b0;
   int  gaps = 0;
   int  extra = 0;
   int  bad_bits = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   wg_pattern_seq #(.ADDR_W(ADDR_W), .STACK_DEPTH(4), .QDEPTH(4)) dut (
      .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
      .prog_data(prog_data), .prog_len(prog_len), .start(start),
      .wave_out(wave_out), .active(active), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: pops expected levels while the design reports an active cycle
   always @(negedge clk) begin
      if (mon_en) begin
         if (active) begin
            if (idle) gaps++;
            seen = 1'b1;
            idle = 1'b0;
            if (exp_q.size() == 0) extra++;
            else begin
               bit e;
               e = exp_q.pop_front();
               n_tests++;
               if (wave_out !== e) begin
                  n_fail++;
                  bad_bits++;
                  $display("FAIL %s waveform level: actual %0d expected %0d",
                           cur_req, wave_out, e);
               end
            end
         end else if (seen) begin
            idle = 1'b1;
         end
      end
   end

   task automatic wr(input int addr, input logic [1:0] op, input int n);
      @(negedge clk);
      prog_we   = 1'b1;
      prog_addr = ADDR_W'(addr);
      prog_data = {op, 14'(n)};
      @(negedge clk);
      prog_we = 1'b0;
   endtask

   task automatic exp_seg(input bit lvl, input int n);
      for (int i = 0; i < n; i++) exp_q.push_back(lvl);
   endtask

   task automatic run_prog(input int len, input bit gap_chk, input string req);
      int cyc;
      cur_req = req;
      gaps = 0; seen = 1'b0; idle = 1'b0; extra = 0;
      mon_en = 1'b1;
      @(negedge clk);
      prog_len = (ADDR_W+1)'(len);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b0, "R8", "done low after start", done, 0);
      cyc = 0;
      while (!done && cyc < 4000) begin
         @(negedge clk);
         cyc++;
      end
      mon_en = 1'b0;
      chk(done == 1'b1, req, "program completed", done, 1);
      chk(exp_q.size() == 0, req, "levels left unplayed", exp_q.size(), 0);
      chk(extra == 0, req, "unexpected active cycles", extra, 0);
      if (gap_chk) chk(gaps == 0, "R7", "idle cycles between segments", gaps, 0);
      chk(!wave_out && !active, "R8", "line low at done", {wave_out, active}, 0);
      exp_q.delete();
   endtask

   initial begin
      #(20ns * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!wave_out && !active && !done, "R8", "reset outputs", {wave_out, active, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R9: plain segments
      wr(0, 2'b00, 3); wr(1, 2'b01, 2); wr(2, 2'b00, 1); wr(3, 2'b01, 4);
      exp_seg(1, 3); exp_seg(0, 2); exp_seg(1, 1); exp_seg(0, 4);
      run_prog(4, 1'b1, "R1");
      repeat (5) @(negedge clk);
      chk(done && !wave_out, "R8", "done held without start", {done, wave_out}, 2);

      // R9: replay stored program
      exp_seg(1, 3); exp_seg(0, 2); exp_seg(1, 1); exp_seg(0, 4);
      run_prog(4, 1'b1, "R9");

      // R3 R4: single loop
      wr(0, 2'b10, 3); wr(1, 2'b00, 2); wr(2, 2'b01, 2); wr(3, 2'b11, 0); wr(4, 2'b00, 3);
      for (int i = 0; i < 3; i++) begin exp_seg(1, 2); exp_seg(0, 2); end
      exp_seg(1, 3);
      run_prog(5, 1'b1, "R3");

      // R4: nested loop with distinct counts
      wr(0, 2'b10, 2); wr(1, 2'b00, 2); wr(2, 2'b10, 3); wr(3, 2'b01, 1);
      wr(4, 2'b11, 0); wr(5, 2'b11, 0);
      for (int i = 0; i < 2; i++) begin exp_seg(1, 2); exp_seg(0, 3); end
      run_prog(6, 1'b0, "R4");

      // R5: four nested levels
      wr(0, 2'b10, 2); wr(1, 2'b10, 2); wr(2, 2'b10, 2); wr(3, 2'b10, 3);
      wr(4, 2'b00, 1); wr(5, 2'b01, 1);
      wr(6, 2'b11, 0); wr(7, 2'b11, 0); wr(8, 2'b11, 0); wr(9, 2'b11, 0);
      for (int i = 0; i < 24; i++) begin exp_seg(1, 1); exp_seg(0, 1); end
      run_prog(10, 1'b0, "R5");

      // R6 R4: zero counts, zero loop with nested body, stray loop end
      wr(0, 2'b11, 0); wr(1, 2'b00, 0); wr(2, 2'b01, 4); wr(3, 2'b10, 0);
      wr(4, 2'b00, 5); wr(5, 2'b10, 2); wr(6, 2'b00, 1); wr(7, 2'b11, 0);
      wr(8, 2'b11, 0); wr(9, 2'b00, 2);
      exp_seg(0, 4); exp_seg(1, 2);
      run_prog(10, 1'b0, "R6");

      // R1 R2 R7: long counts, hex-written value
      wr(0, 2'b00, 300); wr(1, 2'b01, 14'h1A); wr(2, 2'b00, 1);
      exp_seg(1, 300); exp_seg(0, 26); exp_seg(1, 1);
      run_prog(3, 1'b1, "R2");

      // R8: empty program
      run_prog(0, 1'b0, "R8");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule